// File: doc/BRIEF.md
# Eight-Channel Bus DMA Engine

This block moves bytes between a 24-bit CPU memory bus and a 256-byte peripheral register page. Eight channels can each be set up through a byte-wide configuration port. A channel's setup holds a control byte, a destination offset inside the peripheral page, a 16-bit source offset, an 8-bit bank and a 16-bit byte count. A write of a start mask arms the selected channels. The engine then runs them one after another. Each channel finishes before the next one begins.

Each transfer step is one byte read followed by one byte write, on two request/ready ports. The control byte sets the direction. It also sets how the memory offset moves (fixed, up or down) and the transfer type. The transfer type selects the pattern of peripheral offsets that the bytes of a channel visit. When a channel ends, its armed bit clears. A one-cycle done pulse follows once no armed channel is left.

Configuration address: bits [2:0] select the field (0 control, 1 destination offset, 2 source offset low, 3 source offset high, 4 bank, 5 count low, 6 count high) and the bits above them select the channel.

Top module: `bdma_engine`

## Requirements
- R1: Control bit 7 sets the direction. At 0 each step reads memory and writes the peripheral. At 1 each step reads the peripheral and writes memory. The written byte is the byte just read.
- R2: Control bits [2:0] give the peripheral offset for byte j of a channel (j counts from 0), added to the destination offset modulo 256. Type 0 adds 0. Type 1 adds j mod 2. Type 2 adds 0. Type 3 adds (j/2) mod 2. Type 4 adds j mod 4. Types 5 to 7 add 0.
- R3: The upper byte of the peripheral address is always 0x21.
- R4: The memory address is {bank, offset}. When control bit 3 is 0, the offset moves by one after each byte: down if control bit 4 is 1, otherwise up. It wraps within 16 bits and never changes the bank.
- R5: When control bit 3 is 1, every byte of the channel uses the starting memory address.
- R6: A channel moves exactly as many bytes as its count. A count of 0 moves 65536 bytes.
- R7: Bit i of the start mask arms channel i. Armed channels run from the lowest index to the highest, each to completion.
- R8: A channel's armed bit clears when its last byte is written. A single done pulse follows once no channel is armed.
- R9: A request holds its address, direction and data until ready is seen high in the same cycle.
- R10: The memory and peripheral ports are never requested in the same cycle.
- R11: After reset no channel is armed, no request is raised and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 6 | Channel (upper bits) and field (bits [2:0]) |
| cfg_wdata | input | 8 | Configuration byte |
| go_we | input | 1 | Start mask write strobe |
| go_mask | input | 8 | Channels to arm |
| armed | output | 8 | Armed bit per channel |
| done | output | 1 | One-cycle pulse after the last armed channel |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| per_req | output | 1 | Peripheral request |
| per_we | output | 1 | Peripheral write (1) or read (0) |
| per_addr | output | 16 | Peripheral byte address |
| per_wdata | output | 8 | Peripheral write data |
| per_rdata | input | 8 | Peripheral read data, valid with ready |
| per_ready | input | 1 | Peripheral accepts the request this cycle |

## Verification
The assertions check the following on every cycle: requests stay stable under back-pressure, the two ports are never both requested, the bank does not change within a channel, the lowest armed channel is the one loaded, and a finished channel's armed bit drops. Only the bench scenarios can show the address sequences. These cover the transfer-type offset patterns, increment, decrement and fixed movement with wrap at the 16-bit boundary, and the data carried in both directions. They also cover the exact byte counts, including the 65536-byte case, and the order of several armed channels.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  localparam logic [7:0] PER_PAGE = 8'h21;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [7:0]  dest;
    logic [15:0] src;
    logic [7:0]  bank;
    logic [15:0] cnt;
  } chan_cfg_t;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_RD, S_WR, S_NEXT} seq_st_t;

  // peripheral offset pattern by transfer type and byte index (mod 4)
  function automatic logic [7:0] pat_off(input logic [2:0] kind, input logic [1:0] idx);
    case (kind)
      3'd1:    pat_off = {7'd0, idx[0]};
      3'd3:    pat_off = {7'd0, idx[1]};
      3'd4:    pat_off = {6'd0, idx};
      default: pat_off = 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/bdma_rst_sync.sv
module bdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/bdma_chan_regs.sv
module bdma_chan_regs
  import bdma_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH),
  localparam int AW = CW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [7:0]      cfg_wdata,
  input  logic            go_we,
  input  logic [NCH-1:0]  go_mask,
  input  logic            clr,
  input  logic [CW-1:0]   clr_ch,
  output chan_cfg_t       cfg_q [NCH],
  output logic [NCH-1:0]  armed
);
  logic [NCH-1:0] armed_n;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      armed_n[i] = armed[i];
      if (clr && clr_ch == CW'(i)) armed_n[i] = 1'b0;
      if (go_we && go_mask[i])     armed_n[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= '0;
    else        armed <= armed_n;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = cfg_we && (cfg_addr[AW-1:3] == CW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (hit) begin
        case (cfg_addr[2:0])
          3'd0: cfg_q[g].ctrl       <= cfg_wdata;
          3'd1: cfg_q[g].dest       <= cfg_wdata;
          3'd2: cfg_q[g].src[7:0]   <= cfg_wdata;
          3'd3: cfg_q[g].src[15:8]  <= cfg_wdata;
          3'd4: cfg_q[g].bank       <= cfg_wdata;
          3'd5: cfg_q[g].cnt[7:0]   <= cfg_wdata;
          3'd6: cfg_q[g].cnt[15:8]  <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bdma_seq.sv
module bdma_seq
  import bdma_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  armed,
  input  chan_cfg_t       sel_cfg,
  output logic [CW-1:0]   cur_ch,
  output logic            clr,
  output logic            done,
  output logic            mem_req,
  output logic            mem_we,
  output logic [23:0]     mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  input  logic            mem_ready,
  output logic            per_req,
  output logic            per_we,
  output logic [15:0]     per_addr,
  output logic [7:0]      per_wdata,
  input  logic [7:0]      per_rdata,
  input  logic            per_ready
);
  seq_st_t     st_q, st_n;
  logic [CW-1:0] cur_n;
  logic [15:0] off_q, off_n;
  logic [7:0]  bank_q, bank_n, ctrl_q, ctrl_n, dest_q, dest_n, dbuf_q, dbuf_n;
  logic [16:0] rem_q, rem_n;
  logic [1:0]  idx_q, idx_n;
  logic [CW-1:0] low_idx;
  logic        dir, rd_ok, wr_ok;
  logic [7:0]  rd_data;

  always_comb begin
    low_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) if (armed[i]) low_idx = CW'(i);
  end

  assign dir     = ctrl_q[7];
  assign rd_ok   = dir ? per_ready : mem_ready;
  assign wr_ok   = dir ? mem_ready : per_ready;
  assign rd_data = dir ? per_rdata : mem_rdata;

  always_comb begin
    st_n = st_q; cur_n = cur_ch; off_n = off_q; bank_n = bank_q;
    ctrl_n = ctrl_q; dest_n = dest_q; dbuf_n = dbuf_q; rem_n = rem_q; idx_n = idx_q;
    clr = 1'b0; done = 1'b0;
    case (st_q)
      S_IDLE, S_NEXT: begin
        if (|armed) begin
          cur_n = low_idx;
          st_n  = S_LOAD;
        end else begin
          done = (st_q == S_NEXT);
          st_n = S_IDLE;
        end
      end
      S_LOAD: begin
        off_n  = sel_cfg.src;
        bank_n = sel_cfg.bank;
        ctrl_n = sel_cfg.ctrl;
        dest_n = sel_cfg.dest;
        rem_n  = (sel_cfg.cnt == 16'd0) ? 17'h10000 : {1'b0, sel_cfg.cnt};
        idx_n  = 2'd0;
        st_n   = S_RD;
      end
      S_RD: if (rd_ok) begin
        dbuf_n = rd_data;
        st_n   = S_WR;
      end
      S_WR: if (wr_ok) begin
        idx_n = idx_q + 2'd1;
        rem_n = rem_q - 17'd1;
        if (!ctrl_q[3]) off_n = ctrl_q[4] ? off_q - 16'd1 : off_q + 16'd1;
        if (rem_q == 17'd1) begin
          clr  = 1'b1;
          st_n = S_NEXT;
        end else begin
          st_n = S_RD;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cur_ch <= '0; off_q <= '0; bank_q <= '0; ctrl_q <= '0;
      dest_q <= '0; dbuf_q <= '0; rem_q <= '0; idx_q <= '0;
    end else begin
      st_q <= st_n; cur_ch <= cur_n; off_q <= off_n; bank_q <= bank_n; ctrl_q <= ctrl_n;
      dest_q <= dest_n; dbuf_q <= dbuf_n; rem_q <= rem_n; idx_q <= idx_n;
    end
  end

  assign mem_req   = (st_q == S_RD && !dir) || (st_q == S_WR && dir);
  assign per_req   = (st_q == S_RD && dir)  || (st_q == S_WR && !dir);
  assign mem_we    = (st_q == S_WR);
  assign per_we    = (st_q == S_WR);
  assign mem_addr  = {bank_q, off_q};
  assign per_addr  = {PER_PAGE, dest_q + pat_off(ctrl_q[2:0], idx_q)};
  assign mem_wdata = dbuf_q;
  assign per_wdata = dbuf_q;

  // R4: bank is constant while a channel is moving bytes
  a_r4_bank_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q inside {S_RD, S_WR}) && $past(st_q inside {S_RD, S_WR}) |-> bank_q == $past(bank_q));

  // R7: the channel being loaded is armed and nothing below it is armed
  a_r7_pick_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_LOAD |-> armed[cur_ch] && ((armed & ((NCH'(1) << cur_ch) - NCH'(1))) == '0));
endmodule

// File: rtl/bdma_engine.sv
module bdma_engine
  import bdma_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH),
  localparam int AW = CW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [7:0]      cfg_wdata,
  input  logic            go_we,
  input  logic [NCH-1:0]  go_mask,
  output logic [NCH-1:0]  armed,
  output logic            done,
  output logic            mem_req,
  output logic            mem_we,
  output logic [23:0]     mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  input  logic            mem_ready,
  output logic            per_req,
  output logic            per_we,
  output logic [15:0]     per_addr,
  output logic [7:0]      per_wdata,
  input  logic [7:0]      per_rdata,
  input  logic            per_ready
);
  logic          rst_n_s, clr;
  logic [CW-1:0] cur_ch;
  chan_cfg_t     cfg_q [NCH];

  bdma_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  bdma_chan_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .go_we(go_we), .go_mask(go_mask), .clr(clr), .clr_ch(cur_ch), .cfg_q(cfg_q), .armed(armed));

  bdma_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .armed(armed), .sel_cfg(cfg_q[cur_ch]), .cur_ch(cur_ch),
    .clr(clr), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .per_ready(per_ready));

  // R10: one port at a time
  a_r10_one_side: assert property (@(posedge clk) disable iff (!rst_n_s) !(mem_req && per_req));

  // R9: stalled requests hold
  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  a_r9_per_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    per_req && !per_ready |=> per_req && $stable(per_addr) && $stable(per_we) && $stable(per_wdata));

  // R8: finishing a channel drops its armed bit unless re-armed in the same cycle
  a_r8_bit_clears: assert property (@(posedge clk) disable iff (!rst_n_s)
    clr && !go_we |=> !armed[cur_ch]);
endmodule

// File: tb/bdma_engine_bench.sv
module bdma_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        go_we = 1'b0;
  logic [7:0]  go_mask = '0;
  logic [7:0]  armed;
  logic        done;
  logic        mem_req, mem_we, per_req, per_we;
  logic [23:0] mem_addr;
  logic [15:0] per_addr;
  logic [7:0]  mem_wdata, per_wdata, mem_rdata, per_rdata;
  logic        mem_ready = 1'b0, per_ready = 1'b0;

  int checks = 0, errors = 0, cycles = 0;
  bit stall = 0;
  logic [7:0] lfsr = 8'h5B;

  // per-channel expectations
  logic [7:0]  c_ctrl [8];
  logic [7:0]  c_dest [8];
  logic [15:0] c_src  [8];
  logic [7:0]  c_bank [8];
  int          c_cnt  [8];
  int ord [8];
  int n_ord = 0, oi = 0, sdone = 0, bad = 0, total = 0, done_seen = 0;

  always #10 clk = ~clk;

  bdma_engine u_bdma_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .go_we(go_we), .go_mask(go_mask), .armed(armed), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .per_ready(per_ready));

  function automatic logic [7:0] mem_val(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] per_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign mem_rdata = mem_val(mem_addr);
  assign per_rdata = per_val(per_addr);

  function automatic int exp_off(input logic [2:0] kind, input int j);
    case (kind)
      3'd1: return j % 2;
      3'd3: return (j / 2) % 2;
      3'd4: return j % 4;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic take_write(input bit on_mem, input logic [23:0] addr, input logic [7:0] data);
    int ch, j;
    logic [15:0] off;
    logic [23:0] em;
    logic [15:0] ep;
    if (oi >= n_ord) begin
      bad++;
      return;
    end
    ch = ord[oi]; j = sdone;
    if (c_ctrl[ch][3])      off = c_src[ch];
    else if (c_ctrl[ch][4]) off = c_src[ch] - 16'(j);
    else                    off = c_src[ch] + 16'(j);
    em = {c_bank[ch], off};
    ep = {8'h21, c_dest[ch] + 8'(exp_off(c_ctrl[ch][2:0], j))};
    if (c_ctrl[ch][7]) begin
      if (!on_mem || addr != em || data != per_val(ep)) begin
        if (bad == 0) $display("first mismatch ch%0d byte %0d: addr %h data %h, want %h %h", ch, j, addr, data, em, per_val(ep));
        bad++;
      end
    end else begin
      if (on_mem || addr[15:0] != ep || data != mem_val(em)) begin
        if (bad == 0) $display("first mismatch ch%0d byte %0d: addr %h data %h, want %h %h", ch, j, addr, data, ep, mem_val(em));
        bad++;
      end
    end
    sdone++; total++;
    if (sdone == c_cnt[ch]) begin oi++; sdone = 0; end
  endtask

  // drive ready and record handshakes at the falling edge
  always @(negedge clk) begin
    logic mr, pr;
    cycles++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mr = stall ? (lfsr[0] | lfsr[2]) : 1'b1;
    pr = stall ? (lfsr[1] | lfsr[4]) : 1'b1;
    if (rst_n) begin
      if (done) done_seen++;
      if (mem_req && mem_we && mr) take_write(1'b1, mem_addr, mem_wdata);
      if (per_req && per_we && pr) take_write(1'b0, {8'h00, per_addr}, per_wdata);
    end
    mem_ready <= mr;
    per_ready <= pr;
  end

  task automatic cfg_wr(input int ch, input int fld, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'((ch << 3) | fld); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int ch, input logic [7:0] ctrl, input logic [7:0] dest,
                       input logic [15:0] src, input logic [7:0] bank, input logic [15:0] cnt);
    c_ctrl[ch] = ctrl; c_dest[ch] = dest; c_src[ch] = src; c_bank[ch] = bank;
    c_cnt[ch] = (cnt == 0) ? 65536 : int'(cnt);
    cfg_wr(ch, 0, ctrl); cfg_wr(ch, 1, dest);
    cfg_wr(ch, 2, src[7:0]); cfg_wr(ch, 3, src[15:8]); cfg_wr(ch, 4, bank);
    cfg_wr(ch, 5, cnt[7:0]); cfg_wr(ch, 6, cnt[15:8]);
  endtask

  task automatic run(input logic [7:0] mask, input string tag);
    int want = 0;
    n_ord = 0; oi = 0; sdone = 0; bad = 0; total = 0; done_seen = 0;
    for (int i = 0; i < 8; i++) if (mask[i]) begin ord[n_ord] = i; n_ord++; want += c_cnt[i]; end
    @(negedge clk);
    go_we = 1'b1; go_mask = mask;
    @(negedge clk);
    go_we = 1'b0;
    check(armed == mask, "R7 armed after start", int'(armed), int'(mask));
    while (done_seen == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(bad == 0, {tag, " R1 R2 R3 R4 R5 R9 R10 byte sequence mismatches"}, bad, 0);
    check(total == want && oi == n_ord, {tag, " R6 R7 bytes moved"}, total, want);
    check(done_seen == 1 && armed == 8'h00, {tag, " R8 single done, bits cleared"}, done_seen * 256 + int'(armed), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(armed == 0 && !mem_req && !per_req && !done, "R11 reset state",
          {armed, mem_req, per_req, done}, 0);

    // sweep direction x transfer type x address mode
    for (int d = 0; d < 2; d++)
      for (int t = 0; t < 5; t++)
        for (int m = 0; m < 3; m++) begin
          logic [7:0] ctrl;
          int ch;
          ch = (t + m + d) % 8;
          ctrl = {d[0], 2'b00, (m == 1), (m == 2), t[2:0]};
          stall = ((t + m) % 2) == 1;
          setup(ch, ctrl, 8'(8'h18 + t * 4), 16'(16'h1200 + t * 16 + m), 8'(8'h40 + d), 16'd7);
          run(8'(1 << ch), "sweep");
        end

    // 16-bit wrap, both ways, bank must stay
    stall = 1;
    setup(3, 8'h01, 8'h80, 16'hFFFE, 8'h7E, 16'd4);
    run(8'h08, "R4 wrap up");
    setup(6, 8'h94, 8'hFE, 16'h0001, 8'hC3, 16'd5);
    run(8'h40, "R4 R2 wrap down, dest wrap");

    // several channels armed at once
    setup(7, 8'h03, 8'h10, 16'h0300, 8'h01, 16'd2);
    setup(2, 8'h84, 8'h20, 16'h0100, 8'h02, 16'd3);
    setup(5, 8'h09, 8'h30, 16'h0200, 8'h03, 16'd5);
    run(8'hA4, "R7 ordering");

    // count 0 = 65536 bytes
    stall = 0;
    setup(0, 8'h08, 8'h04, 16'h4321, 8'h11, 16'd0);
    run(8'h01, "R6 zero count");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 195000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule